// File: doc/BRIEF.md
# Byte Accumulator ALU with Carry, Half-Carry and Overflow Flags

The block is the arithmetic and logic stage of a small 8-bit accumulator machine. Each cycle it takes the accumulator byte, a second operand byte, the current carry, half-carry and overflow flags and a 4-bit operation code. It returns the result byte at once, as combinational logic. It also returns one write-enable per flag, which shows which flags the operation owns.

The three flags are held in registers inside the block. On each rising clock edge a flag register takes its new value only when the current operation enables that flag. Otherwise it keeps its old value. The surrounding core normally feeds the registered flags back as the flag inputs. The inputs are separate ports, so a core can also supply flag values from elsewhere.

The operations are:
- binary add, with or without the incoming carry;
- subtract with borrow;
- increment and decrement;
- the bitwise operations;
- clear and complement;
- four rotates;
- nibble exchange;
- packed-BCD decimal correction.

Top module: `byte_alu`

## Requirements
- R1: Opcode 0 (add) and opcode 1 (add plus incoming carry) return the low 8 bits of the sum. Carry is set on a carry out of bit 7. Half-carry is set on a carry out of bit 3. Overflow is set when the two's-complement sum does not fit in 8 bits. Each flag is cleared otherwise.
- R2: Opcode 2 (subtract with borrow) returns accumulator minus operand minus incoming carry, modulo 256. Carry is set on a borrow out of bit 7 and half-carry on a borrow out of bit 3. Overflow is set when the signed difference does not fit in 8 bits, which is the same as a borrow into bit 6 without one into bit 7, or the reverse.
- R3: Opcode 3 adds one and opcode 4 subtracts one, modulo 256 (FFh goes to 00h, 00h goes to FFh). Neither opcode writes any flag.
- R4: Opcodes 5, 6 and 7 give the bitwise AND, OR and XOR of the two bytes. Opcode 8 gives 00h. Opcode 9 gives the bitwise inverse of the accumulator. None of these opcodes writes a flag.
- R5: Opcode 10 rotates the accumulator left one place, with bit 7 entering bit 0. Opcode 12 rotates right one place, with bit 0 entering bit 7. Opcode 14 exchanges bits 7..4 with bits 3..0. None of these opcodes writes a flag.
- R6: Opcode 11 rotates left through carry: bit 7 goes to carry and the old carry goes to bit 0. Opcode 13 rotates right through carry: bit 0 goes to carry and the old carry goes to bit 7. Only the carry flag is written.
- R7: Opcode 15 (decimal correction) first adds 06h when the low nibble is above 9 or half-carry is set. It then adds 60h when the high nibble of that intermediate value is above 9, or when carry is set, or when the first step carried out of bit 7. Carry becomes set if either step carries out of bit 7, and it is never cleared by this opcode. Only the carry flag is written.
- R8: All three write-enables are high for opcodes 0 to 2. Only the carry write-enable is high for opcodes 11, 13 and 15. All three are low for every other opcode.
- R9: The registered flags are 0 during reset. After a clock edge, a flag register holds the new value only if its write-enable was high in that cycle. Otherwise it keeps its old value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset of the flag registers |
| opSel | input | 4 | Operation code |
| accIn | input | 8 | Accumulator operand |
| srcIn | input | 8 | Second operand byte |
| cyIn | input | 1 | Incoming carry flag |
| acIn | input | 1 | Incoming half-carry flag |
| ovIn | input | 1 | Incoming overflow flag |
| resultOut | output | 8 | Combinational result byte |
| cyWe | output | 1 | Carry write-enable for this operation |
| acWe | output | 1 | Half-carry write-enable for this operation |
| ovWe | output | 1 | Overflow write-enable for this operation |
| cyQ | output | 1 | Registered carry flag |
| acQ | output | 1 | Registered half-carry flag |
| ovQ | output | 1 | Registered overflow flag |

## Verification
The assertions check several properties on every cycle:
- the write-enable pattern of each opcode class;
- that a flag register keeps its value when its enable is low;
- the wrap of increment and decrement;
- the clear and nibble-exchange results;
- the carry taken by the carry rotates;
- the carry of a plain add;
- that decimal correction never drops a set carry.

Only the bench's scenarios show the rest:
- the half-carry and overflow values of add and subtract over many operand mixes;
- the two-step nibble correction with its intermediate carry;
- a long run of mixed operations in which the registered flags must follow a running model.

// File: rtl/byte_alu_pkg.sv
package byte_alu_pkg;

  localparam int BYTE_W = 8;
  localparam int NIB_W  = BYTE_W / 2;
  localparam int OP_W   = 4;

  // Decimal correction constants derived from the nibble width
  localparam logic [BYTE_W-1:0] LOW_FIX  = BYTE_W'(6);
  localparam logic [BYTE_W-1:0] HIGH_FIX = BYTE_W'(6) << NIB_W;
  localparam logic [NIB_W-1:0]  NIB_MAX  = NIB_W'(9);

  typedef enum logic [OP_W-1:0] {
    OP_ADD  = 4'd0,
    OP_ADDC = 4'd1,
    OP_SUBB = 4'd2,
    OP_INC  = 4'd3,
    OP_DEC  = 4'd4,
    OP_AND  = 4'd5,
    OP_OR   = 4'd6,
    OP_XOR  = 4'd7,
    OP_CLR  = 4'd8,
    OP_CPL  = 4'd9,
    OP_RL   = 4'd10,
    OP_RLC  = 4'd11,
    OP_RR   = 4'd12,
    OP_RRC  = 4'd13,
    OP_SWAP = 4'd14,
    OP_DA   = 4'd15
  } aluOp_t;

  typedef enum logic [2:0] {
    U_ARITH,
    U_STEP,
    U_LOGIC,
    U_SHIFT,
    U_DADJ
  } unitSel_t;

  typedef enum logic [2:0] {
    L_AND,
    L_OR,
    L_XOR,
    L_CLR,
    L_CPL
  } logicSel_t;

  typedef enum logic [2:0] {
    S_RL,
    S_RLC,
    S_RR,
    S_RRC,
    S_SWAP
  } shiftSel_t;

  typedef struct packed {
    unitSel_t  unitSel;
    logic      subMode;
    logic      useCarry;
    logic      stepDown;
    logicSel_t logicSel;
    shiftSel_t shiftSel;
    logic      cyWe;
    logic      acWe;
    logic      ovWe;
  } aluStrobe_t;

endpackage

// File: rtl/byte_alu_ctrl.sv
module byte_alu_ctrl
  import byte_alu_pkg::*;
(
  input  logic [OP_W-1:0] opSel,
  output aluStrobe_t      stb
);

  always_comb begin
    stb          = '0;
    stb.unitSel  = U_LOGIC;
    stb.logicSel = L_AND;
    stb.shiftSel = S_RL;
    unique case (aluOp_t'(opSel))
      OP_ADD: begin
        stb.unitSel = U_ARITH;
        stb.cyWe = 1'b1; stb.acWe = 1'b1; stb.ovWe = 1'b1;
      end
      OP_ADDC: begin
        stb.unitSel  = U_ARITH;
        stb.useCarry = 1'b1;
        stb.cyWe = 1'b1; stb.acWe = 1'b1; stb.ovWe = 1'b1;
      end
      OP_SUBB: begin
        stb.unitSel  = U_ARITH;
        stb.subMode  = 1'b1;
        stb.useCarry = 1'b1;
        stb.cyWe = 1'b1; stb.acWe = 1'b1; stb.ovWe = 1'b1;
      end
      OP_INC:  stb.unitSel = U_STEP;
      OP_DEC: begin
        stb.unitSel  = U_STEP;
        stb.stepDown = 1'b1;
      end
      OP_AND:  stb.logicSel = L_AND;
      OP_OR:   stb.logicSel = L_OR;
      OP_XOR:  stb.logicSel = L_XOR;
      OP_CLR:  stb.logicSel = L_CLR;
      OP_CPL:  stb.logicSel = L_CPL;
      OP_RL: begin
        stb.unitSel  = U_SHIFT;
        stb.shiftSel = S_RL;
      end
      OP_RLC: begin
        stb.unitSel  = U_SHIFT;
        stb.shiftSel = S_RLC;
        stb.cyWe     = 1'b1;
      end
      OP_RR: begin
        stb.unitSel  = U_SHIFT;
        stb.shiftSel = S_RR;
      end
      OP_RRC: begin
        stb.unitSel  = U_SHIFT;
        stb.shiftSel = S_RRC;
        stb.cyWe     = 1'b1;
      end
      OP_SWAP: begin
        stb.unitSel  = U_SHIFT;
        stb.shiftSel = S_SWAP;
      end
      OP_DA: begin
        stb.unitSel = U_DADJ;
        stb.cyWe    = 1'b1;
      end
      default: stb.unitSel = U_LOGIC;
    endcase
  end

endmodule

// File: rtl/byte_alu_datapath.sv
module byte_alu_datapath
  import byte_alu_pkg::*;
(
  input  aluStrobe_t        stb,
  input  logic [BYTE_W-1:0] accIn,
  input  logic [BYTE_W-1:0] srcIn,
  input  logic              cyIn,
  input  logic              acIn,
  input  logic              ovIn,
  output logic [BYTE_W-1:0] resultOut,
  output logic              cyNext,
  output logic              acNext,
  output logic              ovNext
);

  localparam int MSB = BYTE_W - 1;

  // Shared adder: subtract is accumulator + ~operand + ~borrow
  logic [BYTE_W-1:0] addOpnd;
  logic              addCin;
  logic [BYTE_W:0]   addSum;
  logic [NIB_W:0]    addLow;
  logic              arCy, arAc, arOv;

  always_comb begin
    addOpnd = stb.subMode ? ~srcIn : srcIn;
    addCin  = stb.subMode ? ~(stb.useCarry & cyIn) : (stb.useCarry & cyIn);
    addSum  = {1'b0, accIn} + {1'b0, addOpnd} + {{BYTE_W{1'b0}}, addCin};
    addLow  = {1'b0, accIn[NIB_W-1:0]} + {1'b0, addOpnd[NIB_W-1:0]}
            + {{NIB_W{1'b0}}, addCin};
    arCy    = addSum[BYTE_W] ^ stb.subMode;
    arAc    = addLow[NIB_W] ^ stb.subMode;
    arOv    = (accIn[MSB] == addOpnd[MSB]) && (addSum[MSB] != accIn[MSB]);
  end

  // Increment / decrement
  logic [BYTE_W-1:0] stepRes;
  always_comb begin
    stepRes = stb.stepDown ? accIn - BYTE_W'(1) : accIn + BYTE_W'(1);
  end

  // Bitwise unit
  logic [BYTE_W-1:0] logicRes;
  always_comb begin
    unique case (stb.logicSel)
      L_AND:   logicRes = accIn & srcIn;
      L_OR:    logicRes = accIn | srcIn;
      L_XOR:   logicRes = accIn ^ srcIn;
      L_CLR:   logicRes = '0;
      L_CPL:   logicRes = ~accIn;
      default: logicRes = '0;
    endcase
  end

  // Rotate / swap unit
  logic [BYTE_W-1:0] shiftRes;
  logic              shiftCy;
  always_comb begin
    shiftCy = cyIn;
    unique case (stb.shiftSel)
      S_RL:   shiftRes = {accIn[MSB-1:0], accIn[MSB]};
      S_RLC: begin
        shiftRes = {accIn[MSB-1:0], cyIn};
        shiftCy  = accIn[MSB];
      end
      S_RR:   shiftRes = {accIn[0], accIn[MSB:1]};
      S_RRC: begin
        shiftRes = {cyIn, accIn[MSB:1]};
        shiftCy  = accIn[0];
      end
      S_SWAP:  shiftRes = {accIn[NIB_W-1:0], accIn[MSB:NIB_W]};
      default: shiftRes = accIn;
    endcase
  end

  // Decimal correction, two sequential nibble steps
  logic [BYTE_W:0] daMid, daEnd;
  logic            daLowFix, daHighFix, daCyMid;
  always_comb begin
    daLowFix  = (accIn[NIB_W-1:0] > NIB_MAX) || acIn;
    daMid     = {1'b0, accIn} + (daLowFix ? {1'b0, LOW_FIX} : '0);
    daCyMid   = cyIn | daMid[BYTE_W];
    daHighFix = (daMid[MSB:NIB_W] > NIB_MAX) || daCyMid;
    daEnd     = {1'b0, daMid[MSB:0]} + (daHighFix ? {1'b0, HIGH_FIX} : '0);
  end

  // Result and flag select
  always_comb begin
    resultOut = logicRes;
    cyNext    = cyIn;
    acNext    = acIn;
    ovNext    = ovIn;
    unique case (stb.unitSel)
      U_ARITH: begin
        resultOut = addSum[MSB:0];
        cyNext    = arCy;
        acNext    = arAc;
        ovNext    = arOv;
      end
      U_STEP:  resultOut = stepRes;
      U_LOGIC: resultOut = logicRes;
      U_SHIFT: begin
        resultOut = shiftRes;
        cyNext    = shiftCy;
      end
      U_DADJ: begin
        resultOut = daEnd[MSB:0];
        cyNext    = daCyMid | daEnd[BYTE_W];
      end
      default: resultOut = logicRes;
    endcase
  end

endmodule

// File: rtl/byte_alu.sv
module byte_alu
  import byte_alu_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic [OP_W-1:0]   opSel,
  input  logic [BYTE_W-1:0] accIn,
  input  logic [BYTE_W-1:0] srcIn,
  input  logic              cyIn,
  input  logic              acIn,
  input  logic              ovIn,
  output logic [BYTE_W-1:0] resultOut,
  output logic              cyWe,
  output logic              acWe,
  output logic              ovWe,
  output logic              cyQ,
  output logic              acQ,
  output logic              ovQ
);

  aluStrobe_t stb;
  logic cyNext, acNext, ovNext;

  byte_alu_ctrl u_ctrl (
    .opSel (opSel),
    .stb   (stb)
  );

  byte_alu_datapath u_dp (
    .stb       (stb),
    .accIn     (accIn),
    .srcIn     (srcIn),
    .cyIn      (cyIn),
    .acIn      (acIn),
    .ovIn      (ovIn),
    .resultOut (resultOut),
    .cyNext    (cyNext),
    .acNext    (acNext),
    .ovNext    (ovNext)
  );

  assign cyWe = stb.cyWe;
  assign acWe = stb.acWe;
  assign ovWe = stb.ovWe;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cyQ <= 1'b0;
      acQ <= 1'b0;
      ovQ <= 1'b0;
    end else begin
      if (stb.cyWe) cyQ <= cyNext;
      if (stb.acWe) acQ <= acNext;
      if (stb.ovWe) ovQ <= ovNext;
    end
  end

endmodule

// File: rtl/byte_alu_chk.sv
module byte_alu_chk
  import byte_alu_pkg::*;
(
  input logic              clk,
  input logic              rstN,
  input logic [OP_W-1:0]   opSel,
  input logic [BYTE_W-1:0] accIn,
  input logic [BYTE_W-1:0] srcIn,
  input logic              cyIn,
  input logic              acIn,
  input logic              ovIn,
  input logic [BYTE_W-1:0] resultOut,
  input logic              cyWe,
  input logic              acWe,
  input logic              ovWe,
  input logic              cyQ,
  input logic              acQ,
  input logic              ovQ
);

  logic arithOp, carryOnlyOp;
  assign arithOp     = (opSel == OP_ADD) || (opSel == OP_ADDC) || (opSel == OP_SUBB);
  assign carryOnlyOp = (opSel == OP_RLC) || (opSel == OP_RRC) || (opSel == OP_DA);

  AST_ARITH_WE: assert property (@(posedge clk) disable iff (!rstN)
    arithOp |-> (cyWe && acWe && ovWe)); // R8
  AST_CARRY_ONLY_WE: assert property (@(posedge clk) disable iff (!rstN)
    carryOnlyOp |-> (cyWe && !acWe && !ovWe)); // R8
  AST_QUIET_WE: assert property (@(posedge clk) disable iff (!rstN)
    (!arithOp && !carryOnlyOp) |-> (!cyWe && !acWe && !ovWe)); // R4
  AST_CY_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !cyWe |=> $stable(cyQ)); // R9
  AST_AC_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !acWe |=> $stable(acQ)); // R9
  AST_OV_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !ovWe |=> $stable(ovQ)); // R9
  AST_INC_WRAP: assert property (@(posedge clk) disable iff (!rstN)
    (opSel == OP_INC && accIn == 8'hFF) |-> resultOut == 8'h00); // R3
  AST_DEC_WRAP: assert property (@(posedge clk) disable iff (!rstN)
    (opSel == OP_DEC && accIn == 8'h00) |-> resultOut == 8'hFF); // R3
  AST_CLR_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (opSel == OP_CLR) |-> resultOut == 8'h00); // R4
  AST_SWAP_NIB: assert property (@(posedge clk) disable iff (!rstN)
    (opSel == OP_SWAP) |-> resultOut == {accIn[3:0], accIn[7:4]}); // R5
  AST_RLC_CARRY: assert property (@(posedge clk) disable iff (!rstN)
    (opSel == OP_RLC) |=> cyQ == $past(accIn[7])); // R6
  AST_RRC_CARRY: assert property (@(posedge clk) disable iff (!rstN)
    (opSel == OP_RRC) |=> cyQ == $past(accIn[0])); // R6
  AST_ADD_CARRY: assert property (@(posedge clk) disable iff (!rstN)
    (opSel == OP_ADD) |=> cyQ == ((9'($past(accIn)) + 9'($past(srcIn))) > 9'd255)); // R1
  AST_DA_KEEP_CY: assert property (@(posedge clk) disable iff (!rstN)
    (opSel == OP_DA && cyIn) |=> cyQ); // R7

endmodule

bind byte_alu byte_alu_chk u_chk (.*);

// File: tb/sim_byte_alu.sv
module sim_byte_alu;

  logic       clk = 1'b0;
  logic       rstN;
  logic [3:0] opSel;
  logic [7:0] accIn, srcIn;
  logic       cyIn, acIn, ovIn;
  logic [7:0] resultOut;
  logic       cyWe, acWe, ovWe, cyQ, acQ, ovQ;

  int total = 0;
  int bad   = 0;
  logic expCy, expAc, expOv;

  always #2 clk = ~clk;

  byte_alu u0 (
    .clk(clk), .rstN(rstN), .opSel(opSel), .accIn(accIn), .srcIn(srcIn),
    .cyIn(cyIn), .acIn(acIn), .ovIn(ovIn), .resultOut(resultOut),
    .cyWe(cyWe), .acWe(acWe), .ovWe(ovWe), .cyQ(cyQ), .acQ(acQ), .ovQ(ovQ)
  );

  // Returns {cyWe, acWe, ovWe, cy, ac, ov, result[7:0]}
  function automatic logic [13:0] refOp(input logic [3:0] op, input logic [7:0] a,
                                        input logic [7:0] b, input logic cy,
                                        input logic ac, input logic ov);
    int ai, bi, sa, sb, s, lo, ss, x;
    logic [2:0] we;
    logic nc, na, no;
    logic [7:0] r;
    ai = int'(a); bi = int'(b);
    sa = (ai > 127) ? ai - 256 : ai;
    sb = (bi > 127) ? bi - 256 : bi;
    we = 3'b000; nc = cy; na = ac; no = ov; r = 8'h00;
    case (op)
      4'd0, 4'd1: begin
        x  = (op == 4'd1) ? int'(cy) : 0;
        s  = ai + bi + x;
        lo = (ai % 16) + (bi % 16) + x;
        ss = sa + sb + x;
        r = 8'(s); nc = s > 255; na = lo > 15; no = (ss > 127) || (ss < -128);
        we = 3'b111;
      end
      4'd2: begin
        x  = int'(cy);
        s  = ai - bi - x;
        lo = (ai % 16) - (bi % 16) - x;
        ss = sa - sb - x;
        r = 8'(s); nc = s < 0; na = lo < 0; no = (ss > 127) || (ss < -128);
        we = 3'b111;
      end
      4'd3: r = 8'(ai + 1);
      4'd4: r = 8'(ai + 255);
      4'd5: r = a & b;
      4'd6: r = a | b;
      4'd7: r = a ^ b;
      4'd8: r = 8'h00;
      4'd9: r = 8'(255 - ai);
      4'd10: r = 8'((ai * 2) % 256 + ai / 128);
      4'd11: begin r = 8'((ai * 2) % 256 + int'(cy)); nc = a[7]; we = 3'b100; end
      4'd12: r = 8'(ai / 2 + (ai % 2) * 128);
      4'd13: begin r = 8'(ai / 2 + int'(cy) * 128); nc = a[0]; we = 3'b100; end
      4'd14: r = 8'((ai % 16) * 16 + ai / 16);
      default: begin
        x = ai;
        if ((x % 16) > 9 || ac) x = x + 6;
        if (x > 255) begin nc = 1'b1; x = x - 256; end
        if ((x / 16) > 9 || nc) x = x + 96;
        if (x > 255) begin nc = 1'b1; x = x - 256; end
        r = 8'(x); we = 3'b100;
      end
    endcase
    return {we, nc, na, no, r};
  endfunction

  function automatic string reqOf(input logic [3:0] op);
    case (op)
      4'd0, 4'd1: return "R1";
      4'd2: return "R2";
      4'd3, 4'd4: return "R3";
      4'd5, 4'd6, 4'd7, 4'd8, 4'd9: return "R4";
      4'd10, 4'd12, 4'd14: return "R5";
      4'd11, 4'd13: return "R6";
      default: return "R7";
    endcase
  endfunction

  task automatic check(input string req, input string what, input logic [7:0] act,
                       input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s actual=%02h expected=%02h", req, what, act, exp);
    end
  endtask

  // Drive one op at negedge, check combinational outputs, then registered flags
  task automatic runOp(input logic [3:0] op, input logic [7:0] a, input logic [7:0] b,
                       input logic cy, input logic ac, input logic ov);
    logic [13:0] e;
    e = refOp(op, a, b, cy, ac, ov);
    opSel = op; accIn = a; srcIn = b; cyIn = cy; acIn = ac; ovIn = ov;
    #1;
    check(reqOf(op), "result", resultOut, e[7:0]);
    check("R8", "write-enables", {5'd0, cyWe, acWe, ovWe}, {5'd0, e[13:11]});
    if (e[13]) expCy = e[10];
    if (e[12]) expAc = e[9];
    if (e[11]) expOv = e[8];
    @(posedge clk);
    #1;
    check(e[13:11] == 3'b000 ? "R9" : reqOf(op), "flags", {5'd0, cyQ, acQ, ovQ},
          {5'd0, expCy, expAc, expOv});
    @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int seedDummy;
    seedDummy = $urandom(32'd4242);
    rstN = 1'b0; opSel = 4'd0; accIn = 8'h00; srcIn = 8'h00;
    cyIn = 1'b0; acIn = 1'b0; ovIn = 1'b0;
    expCy = 1'b0; expAc = 1'b0; expOv = 1'b0;
    // Reset with an all-flags op applied; flags must stay 0 (R9)
    opSel = 4'd0; accIn = 8'hFF; srcIn = 8'hFF;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R9", "reset flags", {5'd0, cyQ, acQ, ovQ}, 8'h00);
    rstN = 1'b1;

    // Directed corners
    runOp(4'd0, 8'h7F, 8'h01, 1'b0, 1'b0, 1'b0); // R1 signed overflow, half-carry
    runOp(4'd1, 8'hFF, 8'h00, 1'b1, 1'b0, 1'b0); // R1 carry-in ripples out
    runOp(4'd2, 8'h00, 8'h01, 1'b0, 1'b0, 1'b0); // R2 full borrow
    runOp(4'd2, 8'hC1, 8'h40, 1'b1, 1'b0, 1'b1); // R2
    runOp(4'd2, 8'h80, 8'h01, 1'b0, 1'b0, 1'b0); // R2 signed overflow
    runOp(4'd3, 8'hFF, 8'h00, 1'b1, 1'b1, 1'b1); // R3 wrap up
    runOp(4'd4, 8'h00, 8'h00, 1'b0, 1'b0, 1'b0); // R3 wrap down
    runOp(4'd5, 8'hD3, 8'h75, 1'b0, 1'b0, 1'b0); // R4 -> 51h
    runOp(4'd7, 8'hC3, 8'hAA, 1'b0, 1'b0, 1'b0); // R4 -> 69h
    runOp(4'd9, 8'hC3, 8'h00, 1'b0, 1'b0, 1'b0); // R4 -> 3Ch
    runOp(4'd14, 8'hC3, 8'h00, 1'b0, 1'b0, 1'b0); // R5 -> 3Ch
    runOp(4'd10, 8'hC3, 8'h00, 1'b0, 1'b0, 1'b0); // R5 -> 87h
    runOp(4'd13, 8'hC3, 8'h00, 1'b0, 1'b0, 1'b0); // R6 -> 61h, carry 1
    runOp(4'd11, 8'h43, 8'h00, 1'b1, 1'b0, 1'b0); // R6 -> 87h, carry 0
    runOp(4'd15, 8'h3C, 8'h00, 1'b0, 1'b0, 1'b0); // R7 -> 42h
    runOp(4'd15, 8'h00, 8'h00, 1'b1, 1'b0, 1'b0); // R7 carry kept, -> 60h
    runOp(4'd15, 8'h99, 8'h00, 1'b0, 1'b0, 1'b0); // R7 no correction
    runOp(4'd15, 8'hFA, 8'h00, 1'b0, 1'b0, 1'b0); // R7 low step carries out
    runOp(4'd15, 8'h9A, 8'h00, 1'b0, 1'b0, 1'b0); // R7 intermediate high nibble A

    // Random mix
    for (int i = 0; i < 3000; i++) begin
      runOp(4'($urandom_range(0, 15)), 8'($urandom), 8'($urandom),
            1'($urandom), 1'($urandom), 1'($urandom));
    end

    // Mid-run reset clears flags again (R9)
    rstN = 1'b0;
    @(posedge clk); #1;
    check("R9", "flags after reset", {5'd0, cyQ, acQ, ovQ}, 8'h00);
    expCy = 1'b0; expAc = 1'b0; expOv = 1'b0;

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule